// File: doc/BRIEF.md
# Signed Pulse-Width Row Modulator

This block turns a vector of signed-magnitude 8-bit row codes into timed row pulses and polarity switch selections for a resistive crossbar. It runs on the fast modulation clock. For each row, the seven low bits give the number of clock cycles that the row pulse stays high. The top bit chooses which pair of source-line switches closes, so rows of both signs are driven in the same modulation window. No separate read phase is needed for each sign.

A one-cycle start strobe captures the whole vector into holding registers and opens a window of 127 cycles that all rows share. Every pulse begins on the first cycle of the window. Because the vector is latched, the next vector can be presented at the input while the current window is still running. A busy flag covers the window, and a done flag marks its last cycle.

Top module: `pwm_row_modulator`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every output is low.
- R2: Each row code has the sign in bit 7 and the magnitude in bits 6:0. A row's pulse is high for exactly magnitude cycles, starting on the first cycle after the clock edge that accepts start.
- R3: A row with a nonzero magnitude and sign 0 holds sel_fwd high and sel_rev low for the whole window. sel_fwd ties the positive source line to the low read voltage and the negative source line to the high read voltage.
- R4: A row with a nonzero magnitude and sign 1 holds sel_rev high and sel_fwd low for the whole window. sel_rev is the opposite pairing.
- R5: A row with magnitude 0 gives no pulse and no select, whatever its sign bit (code 0x80 acts as 0x00).
- R6: busy is high for exactly 127 cycles after an accepted start. done is high only on the last of those cycles.
- R7: A start that arrives while busy is high, including on the last cycle, is ignored. Changing row_in without an accepted start has no effect on the outputs.
- R8: row_in is sampled only at the edge that accepts start. A start in the first idle cycle after a window is accepted at once.
- R9: All rows share one window: in its first cycle, every row with a nonzero magnitude has its pulse high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulation clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that opens a window when the block is idle |
| row_in | input | ROWS*8 | Row codes; row r occupies bits 8r+7:8r |
| row_pulse | output | ROWS | Per-row pulse-width-modulated enable |
| sel_fwd | output | ROWS | Switch-pair select for positive rows |
| sel_rev | output | ROWS | Switch-pair select for negative rows |
| busy | output | 1 | High during the modulation window |
| done | output | 1 | High on the final window cycle |

## Verification
The properties assume that start is a synchronous input, meaning it is sampled only at clock edges. They also assume that row_in counts only at accepted starts. This is why the select-stability and pulse-never-rises properties can hold even when row_in moves during a window. The bench drives start and row_in only at falling edges. On purpose, it changes row_in and raises start during busy windows, so that the assumption is exercised and not simply avoided. Random codes from a fixed seed are mixed with directed codes: 0x00, 0x80, 0x01, 0x81, 0x7F and 0xFF.

// File: rtl/smod_pkg.sv
package smod_pkg;
  typedef enum logic [1:0] {
    DRV_IDLE = 2'd0,
    DRV_FWD  = 2'd1,
    DRV_REV  = 2'd2
  } drive_e;
endpackage

// File: rtl/pwm_window_ctrl.sv
module pwm_window_ctrl #(
  parameter int CNT_W = 7,
  parameter int WIN   = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             capture,
  output logic             nxt_active,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WIN - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    capture    = start && !active_q;
    nxt_active = 1'b0;
    nxt_cnt    = '0;
    if (capture) begin
      nxt_active = 1'b1;
    end else if (active_q && cnt_q != LAST_C) begin
      nxt_active = 1'b1;
      nxt_cnt    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
    end else begin
      active_q <= nxt_active;
      cnt_q    <= nxt_cnt;
      done_o   <= nxt_active && (nxt_cnt == LAST_C);
    end
  end

  assign busy_o = active_q;
endmodule

// File: rtl/pwm_row_slice.sv
module pwm_row_slice
  import smod_pkg::*;
#(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [MAG_W:0]   code_in,
  input  logic             nxt_active,
  input  logic [MAG_W-1:0] nxt_cnt,
  output logic             pulse_o,
  output logic             fwd_o,
  output logic             rev_o
);
  logic [MAG_W:0]   hold_q;
  logic [MAG_W:0]   nxt_hold;
  logic [MAG_W-1:0] mag;
  drive_e           drv;

  assign nxt_hold = capture ? code_in : hold_q;
  assign mag      = nxt_hold[MAG_W-1:0];

  always_comb begin
    if (mag == '0)            drv = DRV_IDLE;
    else if (nxt_hold[MAG_W]) drv = DRV_REV;
    else                      drv = DRV_FWD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      pulse_o <= 1'b0;
      fwd_o   <= 1'b0;
      rev_o   <= 1'b0;
    end else begin
      hold_q  <= nxt_hold;
      pulse_o <= nxt_active && (nxt_cnt < mag);
      fwd_o   <= nxt_active && (drv == DRV_FWD);
      rev_o   <= nxt_active && (drv == DRV_REV);
    end
  end
endmodule

// File: rtl/pwm_row_modulator.sv
module pwm_row_modulator #(
  parameter int ROWS  = 8,
  parameter int MAG_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ROWS*(MAG_W+1)-1:0] row_in,
  output logic [ROWS-1:0]           row_pulse,
  output logic [ROWS-1:0]           sel_fwd,
  output logic [ROWS-1:0]           sel_rev,
  output logic                      busy,
  output logic                      done
);
  localparam int CODE_W = MAG_W + 1;
  localparam int WIN    = (1 << MAG_W) - 1;

  logic             capture;
  logic             nxt_active;
  logic [MAG_W-1:0] nxt_cnt;

  pwm_window_ctrl #(.CNT_W(MAG_W), .WIN(WIN)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .capture(capture),
    .nxt_active(nxt_active), .nxt_cnt(nxt_cnt),
    .busy_o(busy), .done_o(done)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pwm_row_slice #(.MAG_W(MAG_W)) u_slice (
      .clk(clk), .rst(rst), .capture(capture),
      .code_in(row_in[r*CODE_W +: CODE_W]),
      .nxt_active(nxt_active), .nxt_cnt(nxt_cnt),
      .pulse_o(row_pulse[r]), .fwd_o(sel_fwd[r]), .rev_o(sel_rev[r])
    );
  end
endmodule

// File: rtl/pwm_row_modulator_chk.sv
module pwm_row_modulator_chk #(
  parameter int ROWS  = 8,
  parameter int MAG_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [ROWS-1:0] row_pulse,
  input logic [ROWS-1:0] sel_fwd,
  input logic [ROWS-1:0] sel_rev,
  input logic            busy,
  input logic            done
);
  localparam int WIN = (1 << MAG_W) - 1;
  localparam logic [MAG_W:0] LAST_C = (MAG_W+1)'(WIN - 1);

  logic [MAG_W:0] win_cnt;
  always_ff @(posedge clk) begin
    if (rst)       win_cnt <= '0;
    else if (busy) win_cnt <= win_cnt + 1'b1;
    else           win_cnt <= '0;
  end

  // R6
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy);
  // R6
  window_len_chk: assert property (@(posedge clk) disable iff (rst) done |-> win_cnt == LAST_C);
  // R6
  window_cap_chk: assert property (@(posedge clk) disable iff (rst) busy |-> win_cnt <= LAST_C);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R3 R4
  sel_excl_chk: assert property (@(posedge clk) disable iff (rst) (sel_fwd & sel_rev) == '0);
  // R5
  pulse_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (row_pulse & ~(sel_fwd | sel_rev)) == '0);
  // R2
  pulse_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (row_pulse & ~$past(row_pulse)) == '0);
  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(sel_fwd) && $stable(sel_rev)));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (row_pulse == '0 && sel_fwd == '0 && sel_rev == '0));
  // R9
  first_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (row_pulse == (sel_fwd | sel_rev)));
endmodule

bind pwm_row_modulator pwm_row_modulator_chk #(.ROWS(ROWS), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .row_pulse(row_pulse), .sel_fwd(sel_fwd),
  .sel_rev(sel_rev), .busy(busy), .done(done)
);

// File: tb/pwm_row_modulator_bench.sv
`timescale 1ns/1ps
module pwm_row_modulator_bench;
  localparam int ROWS = 8;
  localparam int WIN  = 127;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ROWS*8-1:0] row_in = '0;
  logic [ROWS-1:0]   row_pulse, sel_fwd, sel_rev;
  logic              busy, done;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwm_row_modulator #(.ROWS(ROWS), .MAG_W(7)) u_pwm_row_modulator (
    .clk(clk), .rst(rst), .start(start), .row_in(row_in),
    .row_pulse(row_pulse), .sel_fwd(sel_fwd), .sel_rev(sel_rev),
    .busy(busy), .done(done)
  );

  function automatic logic [ROWS-1:0] exp_pulse(logic [ROWS*8-1:0] v, int k);
    for (int r = 0; r < ROWS; r++) exp_pulse[r] = (k < int'(v[r*8 +: 7]));
  endfunction
  function automatic logic [ROWS-1:0] exp_fwd(logic [ROWS*8-1:0] v);
    for (int r = 0; r < ROWS; r++) exp_fwd[r] = (v[r*8 +: 7] != 0) && !v[r*8+7];
  endfunction
  function automatic logic [ROWS-1:0] exp_rev(logic [ROWS*8-1:0] v);
    for (int r = 0; r < ROWS; r++) exp_rev[r] = (v[r*8 +: 7] != 0) && v[r*8+7];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic launch(logic [ROWS*8-1:0] v);
    row_in = v;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic watch(logic [ROWS*8-1:0] v, string ptag, bit poke_mid, bit poke_last);
    for (int k = 0; k < WIN; k++) begin
      chk(ptag, "pulse", 32'(row_pulse), 32'(exp_pulse(v, k)));
      chk("R3", "sel_fwd", 32'(sel_fwd), 32'(exp_fwd(v)));
      chk("R4", "sel_rev", 32'(sel_rev), 32'(exp_rev(v)));
      chk("R6", "busy", 32'(busy), 32'd1);
      chk("R6", "done", 32'(done), 32'(k == WIN - 1));
      if (poke_mid && k == 40) begin row_in = ~v; start = 1'b1; end
      if (poke_mid && k == 41) start = 1'b0;
      if (poke_last && k == WIN - 1) begin row_in = ~v; start = 1'b1; end
      @(negedge clk);
    end
  endtask

  task automatic check_idle(string tag);
    start = 1'b0;
    chk(tag, "idle busy", 32'(busy), 32'd0);
    chk(tag, "idle done", 32'(done), 32'd0);
    chk(tag, "idle pulse", 32'(row_pulse), 32'd0);
    chk(tag, "idle sel", 32'({sel_fwd, sel_rev}), 32'd0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [ROWS*8-1:0] v;
    int unused_seed;
    unused_seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1", "reset outputs", 32'({row_pulse, sel_fwd, sel_rev, busy, done}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "after reset", 32'({row_pulse, sel_fwd, sel_rev, busy, done}), 32'd0);

    // R2 mixed directed codes, start and new data during window (R7)
    launch({8'hC5, 8'h40, 8'h80, 8'h00, 8'hFF, 8'h7F, 8'h81, 8'h01});
    watch({8'hC5, 8'h40, 8'h80, 8'h00, 8'hFF, 8'h7F, 8'h81, 8'h01}, "R2", 1'b1, 1'b0);
    check_idle("R7");

    // R5 all zero magnitudes, both signs
    @(negedge clk);
    v = {8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00};
    launch(v);
    watch(v, "R5", 1'b0, 1'b0);
    check_idle("R5");

    // R8 immediate relaunch in first idle cycle; start on last cycle ignored (R7)
    v = {8'hFF, 8'h7F, 8'hFF, 8'h7F, 8'hFE, 8'h7E, 8'h82, 8'h02};
    launch(v);
    watch(v, "R8", 1'b0, 1'b1);
    check_idle("R7");

    // R9 all rows magnitude one, common first cycle
    @(negedge clk);
    v = {8'h81, 8'h01, 8'h81, 8'h01, 8'h81, 8'h01, 8'h81, 8'h01};
    launch(v);
    chk("R9", "first cycle pulses", 32'(row_pulse), 32'hFF);
    watch(v, "R9", 1'b0, 1'b0);
    check_idle("R6");

    // R2 random codes with occasional zeros
    for (int w = 0; w < 6; w++) begin
      for (int r = 0; r < ROWS; r++) begin
        v[r*8 +: 8] = 8'($urandom);
        if (($urandom % 6) == 0) v[r*8 +: 7] = '0;
      end
      @(negedge clk);
      launch(v);
      watch(v, "R2", (w % 2) == 1, 1'b0);
      check_idle("R6");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule